// File: doc/BRIEF.md
# Interpolating Thermometer Envelope Decoder

This block drives the enables of an array of 64 equal-weight unit cells from a 6-bit unsigned envelope code. Each unit cell is split into four sections, and the sections that share one timing slot form a quadrant bank. Each bank therefore has its own 64-bit enable vector. The code is decoded as a row/column thermometer: the upper bits name a partially filled row, every row below it is full, and the lower bits give how many cells of the partial row are on. A fixed scramble of row order and column order spreads the cells over the array.

A sample strobe marks the start of each envelope period. A clock enable runs at four times that rate and steps a sub-phase counter. In interpolate mode the four banks take the new pattern one after another, a quarter period apart, so the summed weight climbs or falls in four smaller steps. In single-phase mode all banks switch on the strobe. In linear-test mode every enable is forced on. A programmable delay of whole sample periods lets the envelope line up with a separately generated phase path.

Top module: `env_interp_decoder`

## Requirements
- R1: After a bank loads a code N, exactly N of its 64 enables are set. Logical cell (row r, column c) is on when r*8+c < N, so code 63 leaves one cell off.
- R2: When the loaded code moves by one LSB, exactly one enable of the bank changes.
- R3: Logical cell (r, c) drives output bit ((5*r+3) mod 8)*8 + ((3*c+1) mod 8) of every bank. For example, code 1 sets bit 25 alone, and code 9 sets bits 24..31 and bit 1.
- R4: With mode_sel = 00 (interpolate), bank 0 loads the delayed code on the strobe edge. Bank k (k = 1..3) loads it on the k-th sub_tick after that strobe. No bank changes on any other edge.
- R5: A strobe sets the sub-phase count to zero and takes priority over a sub_tick in the same cycle. A sub_tick beyond the third in a period loads nothing.
- R6: With mode_sel = 01 (single-phase), all four banks load the delayed code on the strobe edge.
- R7: With mode_sel[1] = 1 (linear test), all 256 enables are one from the next edge, whatever the code.
- R8: The code loaded at a strobe is the env_code presented at the strobe dly_sel strobes earlier (0 to 15). With dly_sel = 0 it is the code presented at the same strobe, and history before reset counts as code 0.
- R9: In interpolate mode at most one bank changes per clock edge.
- R10: A synchronous active-high rst clears all enables, the sub-phase count and the delay history, and it overrides every other input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_vld | input | 1 | Envelope sample strobe, one cycle per sample period |
| sub_tick | input | 1 | Clock enable at four times the sample rate |
| mode_sel | input | 2 | 00 interpolate, 01 single-phase, 1x linear test |
| dly_sel | input | 4 | Envelope delay in whole sample periods |
| env_code | input | 6 | Envelope sample, unsigned |
| qen0 | output | 64 | Enables of quadrant bank 0 |
| qen1 | output | 64 | Enables of quadrant bank 1 |
| qen2 | output | 64 | Enables of quadrant bank 2 |
| qen3 | output | 64 | Enables of quadrant bank 3 |

## Verification
Ascending and descending code ramps in single-phase mode show whether a one-LSB step flips a single cell. Literal patterns for codes 1, 8, 9 and 63 pin down the scramble and the full-scale corner. Back-to-back strobes with surplus ticks, and a strobe that coincides with a tick, separate a correct realign of the sub-phase counter from a counter that wraps or lets the tick win. A fixed delay sequence and randomly mixed codes, modes and delays, checked each cycle against a bench model, tell apart a wrong delay tap, a wrong bank order and a bank that loads on the wrong sub-phase.

// File: rtl/env_interp_pkg.sv
package env_interp_pkg;

  // Operating modes; bit 1 set means every enable is forced on.
  typedef enum logic [1:0] {
    MODE_INTERP = 2'b00,
    MODE_SINGLE = 2'b01,
    MODE_LIN_A  = 2'b10,
    MODE_LIN_B  = 2'b11
  } drive_mode_e;

  // Affine scramble of an index; an odd multiplier keeps it a bijection
  // when n is a power of two.
  function automatic int unsigned perm_idx(input int unsigned idx,
                                           input int unsigned mult,
                                           input int unsigned ofs,
                                           input int unsigned n);
    return (idx * mult + ofs) % n;
  endfunction

endpackage

// File: rtl/env_sample_delay.sv
module env_sample_delay #(
  parameter int W     = 6,
  parameter int DEPTH = 16,
  parameter int SEL_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift_en,
  input  logic [W-1:0]     din,
  input  logic [SEL_W-1:0] tap_sel,
  output logic [W-1:0]     dout
);

  localparam int STAGES = DEPTH - 1;

  logic [W-1:0] stage_q [STAGES];

  // Shift history one sample on every strobe.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else if (shift_en) begin
      stage_q[0] <= din;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  // Tap zero bypasses the history entirely.
  assign dout = (tap_sel == '0) ? din : stage_q[tap_sel - 1'b1];

endmodule

// File: rtl/env_subphase_ctr.sv
module env_subphase_ctr #(
  parameter int NSUB = 4,
  parameter int PH_W = $clog2(NSUB)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            realign,
  input  logic            tick,
  output logic [PH_W-1:0] phase
);

  localparam logic [PH_W-1:0] LAST = PH_W'(NSUB - 1);

  // Realign wins over tick; the count parks on its last value.
  always_ff @(posedge clk) begin
    if (rst)                        phase <= '0;
    else if (realign)               phase <= '0;
    else if (tick && phase != LAST) phase <= phase + 1'b1;
  end

  // R5
  phase_realign_chk: assert property (@(posedge clk) disable iff (rst)
    realign |=> phase == '0);

endmodule

// File: rtl/env_therm_rc_dec.sv
module env_therm_rc_dec #(
  parameter int ROWS     = 8,
  parameter int COLS     = 8,
  parameter int CODE_W   = $clog2(ROWS * COLS),
  parameter int ROW_MULT = 5,
  parameter int ROW_OFS  = 3,
  parameter int COL_MULT = 3,
  parameter int COL_OFS  = 1
) (
  input  logic [CODE_W-1:0]    code,
  output logic [ROWS*COLS-1:0] unit_en
);

  import env_interp_pkg::*;

  localparam int COL_W = $clog2(COLS);
  localparam int ROW_W = CODE_W - COL_W;

  logic [ROW_W-1:0] row_sel;
  logic [COL_W-1:0] col_cnt;

  assign row_sel = code[CODE_W-1:COL_W];
  assign col_cnt = code[COL_W-1:0];

  // Rows under the selected one are full; the selected row fills from
  // column zero up to col_cnt; each cell lands on its scrambled position.
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      localparam int PHYS = perm_idx(r, ROW_MULT, ROW_OFS, ROWS) * COLS
                          + perm_idx(c, COL_MULT, COL_OFS, COLS);
      assign unit_en[PHYS] = (ROW_W'(r) < row_sel) ||
                             ((ROW_W'(r) == row_sel) && (COL_W'(c) < col_cnt));
    end
  end

endmodule

// File: rtl/env_interp_decoder.sv
module env_interp_decoder #(
  parameter int ROWS      = 8,
  parameter int COLS      = 8,
  parameter int CODE_W    = $clog2(ROWS * COLS),
  parameter int DLY_DEPTH = 16,
  parameter int DLY_W     = $clog2(DLY_DEPTH),
  parameter int ROW_MULT  = 5,
  parameter int ROW_OFS   = 3,
  parameter int COL_MULT  = 3,
  parameter int COL_OFS   = 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 smp_vld,
  input  logic                 sub_tick,
  input  logic [1:0]           mode_sel,
  input  logic [DLY_W-1:0]     dly_sel,
  input  logic [CODE_W-1:0]    env_code,
  output logic [ROWS*COLS-1:0] qen0,
  output logic [ROWS*COLS-1:0] qen1,
  output logic [ROWS*COLS-1:0] qen2,
  output logic [ROWS*COLS-1:0] qen3
);

  import env_interp_pkg::*;

  localparam int UNITS = ROWS * COLS;
  localparam int NQUAD = 4;
  localparam int PH_W  = $clog2(NQUAD);

  logic [CODE_W-1:0] sel_code;   // delayed code seen at this strobe
  logic [CODE_W-1:0] tgt_code;   // code held for the later banks
  logic [UNITS-1:0]  sel_pat;
  logic [UNITS-1:0]  tgt_pat;
  logic [PH_W-1:0]   phase;
  logic [UNITS-1:0]  bank_q [NQUAD];
  logic              lin_mode;
  logic              interp_mode;
  logic              single_mode;

  assign lin_mode    = mode_sel[1];
  assign interp_mode = (mode_sel == MODE_INTERP);
  assign single_mode = (mode_sel == MODE_SINGLE);

  env_sample_delay #(
    .W(CODE_W), .DEPTH(DLY_DEPTH), .SEL_W(DLY_W)
  ) u_delay (
    .clk(clk), .rst(rst), .shift_en(smp_vld),
    .din(env_code), .tap_sel(dly_sel), .dout(sel_code)
  );

  always_ff @(posedge clk) begin
    if (rst)          tgt_code <= '0;
    else if (smp_vld) tgt_code <= sel_code;
  end

  env_subphase_ctr #(.NSUB(NQUAD), .PH_W(PH_W)) u_phase (
    .clk(clk), .rst(rst), .realign(smp_vld), .tick(sub_tick), .phase(phase)
  );

  env_therm_rc_dec #(
    .ROWS(ROWS), .COLS(COLS), .CODE_W(CODE_W),
    .ROW_MULT(ROW_MULT), .ROW_OFS(ROW_OFS),
    .COL_MULT(COL_MULT), .COL_OFS(COL_OFS)
  ) u_dec_now (.code(sel_code), .unit_en(sel_pat));

  env_therm_rc_dec #(
    .ROWS(ROWS), .COLS(COLS), .CODE_W(CODE_W),
    .ROW_MULT(ROW_MULT), .ROW_OFS(ROW_OFS),
    .COL_MULT(COL_MULT), .COL_OFS(COL_OFS)
  ) u_dec_tgt (.code(tgt_code), .unit_en(tgt_pat));

  // Bank 0 follows the strobe; bank k follows the tick that ends
  // sub-phase k-1; single-phase mode moves all banks on the strobe.
  for (genvar k = 0; k < NQUAD; k++) begin : g_bank
    localparam bit               LATE    = (k != 0);
    localparam logic [PH_W-1:0]  PREV_PH = PH_W'((k + NQUAD - 1) % NQUAD);
    always_ff @(posedge clk) begin
      if (rst) begin
        bank_q[k] <= '0;
      end else if (lin_mode) begin
        bank_q[k] <= '1;
      end else if (smp_vld) begin
        if (!LATE || single_mode) bank_q[k] <= sel_pat;
      end else if (LATE && sub_tick && interp_mode && phase == PREV_PH) begin
        bank_q[k] <= tgt_pat;
      end
    end
  end

  assign qen0 = bank_q[0];
  assign qen1 = bank_q[1];
  assign qen2 = bank_q[2];
  assign qen3 = bank_q[3];

  // R1
  pop_match_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(sel_pat) == int'(sel_code));

  // R4
  first_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!smp_vld && !lin_mode) |=> $stable(bank_q[0]));

  // R4
  late_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!sub_tick && !lin_mode && !(smp_vld && single_mode)) |=>
      ($stable(bank_q[1]) && $stable(bank_q[2]) && $stable(bank_q[3])));

  // R6
  single_align_chk: assert property (@(posedge clk) disable iff (rst)
    (smp_vld && single_mode) |=>
      (bank_q[0] == bank_q[1] && bank_q[1] == bank_q[2] && bank_q[2] == bank_q[3]));

  // R7
  lin_force_chk: assert property (@(posedge clk) disable iff (rst)
    lin_mode |=> (&bank_q[0] && &bank_q[1] && &bank_q[2] && &bank_q[3]));

  // R9
  one_bank_chk: assert property (@(posedge clk) disable iff (rst)
    interp_mode |=> $countones({bank_q[0] != $past(bank_q[0]),
                                bank_q[1] != $past(bank_q[1]),
                                bank_q[2] != $past(bank_q[2]),
                                bank_q[3] != $past(bank_q[3])}) <= 1);

endmodule

// File: tb/env_interp_decoder_tb.sv
`timescale 1ns/1ps
module env_interp_decoder_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        smp_vld = 1'b0;
  logic        sub_tick = 1'b0;
  logic [1:0]  mode_sel = 2'b00;
  logic [3:0]  dly_sel = 4'd0;
  logic [5:0]  env_code = 6'd0;
  logic [63:0] qen0, qen1, qen2, qen3;
  logic [63:0] dq [4];

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  string cur_tag = "R10";

  // reference model state
  logic [5:0]  m_hist [15];
  logic [5:0]  m_tgt;
  int          m_cnt;
  logic [63:0] m_q [4];

  always #2 clk = ~clk;

  env_interp_decoder dut_i (
    .clk(clk), .rst(rst), .smp_vld(smp_vld), .sub_tick(sub_tick),
    .mode_sel(mode_sel), .dly_sel(dly_sel), .env_code(env_code),
    .qen0(qen0), .qen1(qen1), .qen2(qen2), .qen3(qen3)
  );

  assign dq[0] = qen0;
  assign dq[1] = qen1;
  assign dq[2] = qen2;
  assign dq[3] = qen3;

  // Expected pattern from the cell rule and the scramble of R1/R3.
  function automatic logic [63:0] exp_pat(input int code);
    logic [63:0] p = '0;
    for (int r = 0; r < 8; r++)
      for (int c = 0; c < 8; c++)
        if (r * 8 + c < code) p[((5 * r + 3) % 8) * 8 + ((3 * c + 1) % 8)] = 1'b1;
    return p;
  endfunction

  task automatic chk(input string tag, input bit ok, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < 15; i++) m_hist[i] = '0;
    m_tgt = '0;
    m_cnt = 0;
    for (int k = 0; k < 4; k++) m_q[k] = '0;
  endtask

  // One clock: drive on the falling edge, predict, compare after the edge.
  task automatic cyc(input bit v, input bit t, input logic [1:0] m,
                     input logic [3:0] d, input logic [5:0] c);
    logic [63:0] nq  [4];
    logic [63:0] pre [4];
    logic [5:0]  sel;
    int          changed;
    @(negedge clk);
    smp_vld = v; sub_tick = t; mode_sel = m; dly_sel = d; env_code = c;
    sel = (d == 0) ? c : m_hist[d - 1];
    for (int k = 0; k < 4; k++) begin nq[k] = m_q[k]; pre[k] = dq[k]; end
    if (m[1]) begin
      for (int k = 0; k < 4; k++) nq[k] = '1;
    end else if (v) begin
      nq[0] = exp_pat(sel);
      if (m == 2'b01) for (int k = 1; k < 4; k++) nq[k] = exp_pat(sel);
    end else if (t && m == 2'b00 && m_cnt < 3) begin
      nq[m_cnt + 1] = exp_pat(m_tgt);
    end
    @(posedge clk);
    #1;
    if (v) begin
      m_tgt = sel;
      for (int i = 14; i > 0; i--) m_hist[i] = m_hist[i - 1];
      m_hist[0] = c;
      m_cnt = 0;
    end else if (t && m_cnt < 3) begin
      m_cnt = m_cnt + 1;
    end
    for (int k = 0; k < 4; k++) begin
      m_q[k] = nq[k];
      chk(cur_tag, dq[k] === nq[k], dq[k], nq[k]);
    end
    if (m == 2'b00) begin
      changed = 0;
      for (int k = 0; k < 4; k++) if (dq[k] !== pre[k]) changed++;
      chk("R9", changed <= 1, 64'(changed), 64'd1);
    end
  endtask

  // One sample period: 16 clocks, a tick every fourth clock.
  task automatic sample(input logic [1:0] m, input logic [3:0] d, input logic [5:0] c);
    for (int i = 0; i < 16; i++) cyc(i == 0, (i % 4) == 0, m, d, c);
    if (!m[1])
      for (int k = 0; k < 4; k++)
        chk("R1", $countones(dq[k]) == int'(m_tgt), 64'($countones(dq[k])), 64'(m_tgt));
  endtask

  task automatic print_summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    logic [63:0] prev;
    int          hd;
    void'($urandom(32'd20240611));
    model_clear();

    // R10: reset dominates a strobe in linear-test mode
    rst = 1'b1; smp_vld = 1'b1; mode_sel = 2'b10; env_code = 6'd55;
    repeat (3) @(posedge clk);
    #1;
    for (int k = 0; k < 4; k++) chk("R10", dq[k] === 64'd0, dq[k], 64'd0);
    @(negedge clk);
    rst = 1'b0; smp_vld = 1'b0; mode_sel = 2'b00;

    // R3: literal scramble positions, single-phase, no delay
    cur_tag = "R3";
    sample(2'b01, 4'd0, 6'd1);
    chk("R3", qen0 === 64'h0000_0000_0200_0000, qen0, 64'h0000_0000_0200_0000);
    sample(2'b01, 4'd0, 6'd8);
    chk("R3", qen0 === 64'h0000_0000_FF00_0000, qen0, 64'h0000_0000_FF00_0000);
    sample(2'b01, 4'd0, 6'd9);
    chk("R3", qen2 === 64'h0000_0000_FF00_0002, qen2, 64'h0000_0000_FF00_0002);
    sample(2'b01, 4'd0, 6'd63);
    chk("R1", qen3 === ~(64'd1 << 54), qen3, ~(64'd1 << 54));
    sample(2'b01, 4'd0, 6'd0);
    chk("R1", qen1 === 64'd0, qen1, 64'd0);

    // R2: ramps up and down, one toggle per LSB
    cur_tag = "R2";
    prev = qen0;
    for (int c = 1; c < 64; c++) begin
      sample(2'b01, 4'd0, 6'(c));
      hd = $countones(qen0 ^ prev);
      chk("R2", hd == 1, 64'(hd), 64'd1);
      prev = qen0;
    end
    for (int c = 62; c >= 0; c--) begin
      sample(2'b01, 4'd0, 6'(c));
      hd = $countones(qen0 ^ prev);
      chk("R2", hd == 1, 64'(hd), 64'd1);
      prev = qen0;
    end

    // R4: staircase 0 -> 40 in interpolate mode
    cur_tag = "R4";
    sample(2'b00, 4'd0, 6'd40);

    // R5: strobe with tick, surplus ticks, then a strobe with no ticks
    cur_tag = "R5";
    cyc(1'b1, 1'b1, 2'b00, 4'd0, 6'd17);
    chk("R5", $countones(qen1) == 40, 64'($countones(qen1)), 64'd40);
    for (int i = 0; i < 6; i++) cyc(1'b0, 1'b1, 2'b00, 4'd0, 6'd17);
    chk("R5", $countones(qen3) == 17, 64'($countones(qen3)), 64'd17);
    cyc(1'b1, 1'b0, 2'b00, 4'd0, 6'd33);
    for (int i = 0; i < 3; i++) cyc(1'b0, 1'b0, 2'b00, 4'd0, 6'd33);
    chk("R5", $countones(qen1) == 17, 64'($countones(qen1)), 64'd17);
    cyc(1'b0, 1'b1, 2'b00, 4'd0, 6'd33);
    chk("R5", $countones(qen1) == 33, 64'($countones(qen1)), 64'd33);

    // R8: three-sample delay
    cur_tag = "R8";
    sample(2'b01, 4'd3, 6'd10);
    sample(2'b01, 4'd3, 6'd20);
    sample(2'b01, 4'd3, 6'd30);
    sample(2'b01, 4'd3, 6'd40);
    sample(2'b01, 4'd3, 6'd50);
    chk("R8", $countones(qen0) == 20, 64'($countones(qen0)), 64'd20);

    // R7: linear test ignores a zero code
    cur_tag = "R7";
    sample(2'b10, 4'd0, 6'd0);
    chk("R7", &{qen0, qen1, qen2, qen3}, qen2, '1);
    sample(2'b11, 4'd0, 6'd5);
    chk("R7", &{qen0, qen1, qen2, qen3}, qen0, '1);

    // R6: single-phase with a zero code after linear test
    cur_tag = "R6";
    sample(2'b01, 4'd0, 6'd0);
    chk("R6", qen3 === 64'd0, qen3, 64'd0);

    // random mix of codes, modes and delays
    for (int n = 0; n < 300; n++) begin
      int unsigned r = $urandom % 8;
      logic [1:0]  m = (r < 4) ? 2'b00 : (r < 6) ? 2'b01 : (r < 7) ? 2'b10 : 2'b11;
      if (($urandom % 10) == 0) dly_sel = 4'($urandom % 16);
      cur_tag = (m == 2'b00) ? "R4" : (m == 2'b01) ? "R6" : "R7";
      if (dly_sel != 0 && m != 2'b10 && m != 2'b11) cur_tag = "R8";
      sample(m, dly_sel, 6'($urandom % 64));
    end

    done = 1'b1;
    print_summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      print_summary();
      $finish;
    end
  end

endmodule